// File: doc/BRIEF.md
# Floating-Point Operand Alignment Stage

This block is the front end of a single-precision arithmetic pipeline. It takes two 32-bit IEEE-754 words, splits each into its sign, its 8-bit biased exponent and a 24-bit significand. The significand gets an implicit leading one whenever the exponent field is nonzero. The two exponents are subtracted. The borrow of that subtraction tells which operand is smaller. That borrow steers a combinational right shifter, which moves the smaller operand's significand down by the size of the exponent gap, so that both significands sit on a common binary point.

A single register stage holds the aligned significands, both signs, the borrow and the result exponent. A mode input chooses the result exponent. In add mode it is the larger of the two exponents. In multiply mode it is the biased sum of the two exponents, kept in a 10-bit two's-complement field so that values below zero and above 255 stay visible to later stages. The block does not treat NaN or infinity as special values.

Top module: `fp_align_stage`

## Requirements
- R1: A significand is `{hidden, fraction[22:0]}`, where the hidden bit is 1 when the exponent field (bits 30:23) is nonzero and 0 when it is zero.
- R2: `shift_sel_q` is 1 exactly when the exponent of A is less than the exponent of B, and 0 otherwise.
- R3: When the exponent of A is greater than that of B, `mant_a_q` holds A's significand unchanged and `mant_b_q` holds B's significand shifted right by the exponent difference.
- R4: When the exponent of A is less than that of B, `mant_b_q` holds B's significand unchanged and `mant_a_q` holds A's significand shifted right by the exponent difference.
- R5: When the exponents are equal, neither significand is shifted and `shift_sel_q` is 0.
- R6: A shift of 24 or more places gives an all-zero significand. A shift of 23 keeps only the former top bit.
- R7: With `exp_sum_sel` = 1, `exp_q` is EA + EB − 127 as a 10-bit two's-complement value.
- R8: With `exp_sum_sel` = 0, `exp_q` is the larger of EA and EB, zero-extended to 10 bits.
- R9: `sign_a_q` and `sign_b_q` hold bit 31 of A and of B.
- R10: Every output shows the inputs sampled at the previous rising clock edge. While `rst_n` is low at a rising edge, all outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 32 | Operand A, IEEE-754 single |
| op_b | input | 32 | Operand B, IEEE-754 single |
| exp_sum_sel | input | 1 | 1: exponent sum for multiply; 0: larger exponent |
| sign_a_q | output | 1 | Registered sign of A |
| sign_b_q | output | 1 | Registered sign of B |
| mant_a_q | output | 24 | Aligned significand of A |
| mant_b_q | output | 24 | Aligned significand of B |
| exp_q | output | 10 | Result exponent, two's complement |
| shift_sel_q | output | 1 | Registered borrow: A has the smaller exponent |

## Verification
The hardest cases sit at the edges of the shifter: a gap of exactly 23 or 24, and a gap large enough to drive the upper shift stages. Those stages move the data by more than the significand width and must flush it to zero. The vector table reaches them with exponents picked to land on those gaps in both directions, for example 150 against 127, 151 against 127, and 254 against 0. It also feeds zero-exponent operands, where the hidden bit drops. Multiply-mode vectors with very small and very large exponents push the exponent sum below zero and past 255.

// File: rtl/fpa_pkg.sv
// Shared constants for the alignment stage: default field widths, the
// exponent bias and the encoding of the exponent-path select.
package fpa_pkg;
    localparam int DEF_EXP_W  = 8;
    localparam int DEF_FRAC_W = 23;
    localparam int DEF_BIAS   = 127;

    typedef enum logic {
        EXP_LARGER = 1'b0,
        EXP_SUM    = 1'b1
    } exp_path_e;
endpackage

// File: rtl/fpa_unpack.sv
// Splits one IEEE-754 word into its sign, exponent and significand, and
// restores the hidden bit. Assumes the standard field layout: sign at the
// top, then the exponent, then the fraction.
module fpa_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int MANT_W = FRAC_W + 1
) (
    input  logic [WORD_W-1:0] word,
    output logic              sign,
    output logic [EXP_W-1:0]  expo,
    output logic [MANT_W-1:0] mant
);
    // Field extraction; the hidden bit is set for any nonzero exponent.
    always_comb begin
        sign = word[WORD_W-1];
        expo = word[WORD_W-2 -: EXP_W];
        mant = {(|word[WORD_W-2 -: EXP_W]), word[FRAC_W-1:0]};
    end
endmodule

// File: rtl/fpa_exp_cmp.sv
// Exponent unit: subtracts EB from EA, giving the borrow (A has the smaller
// exponent) and the size of the gap. It also forms the biased sum used for
// multiply. The sum is two bits wider than an exponent so that it never wraps.
module fpa_exp_cmp #(
    parameter int EXP_W = 8,
    parameter int BIAS  = 127,
    localparam int SUM_W = EXP_W + 2
) (
    input  logic [EXP_W-1:0] ea,
    input  logic [EXP_W-1:0] eb,
    output logic             borrow,
    output logic [EXP_W-1:0] gap,
    output logic [EXP_W-1:0] e_large,
    output logic [SUM_W-1:0] e_sum
);
    localparam logic [SUM_W-1:0] BIAS_V = SUM_W'(BIAS);

    logic [EXP_W:0] diff;

    // Subtract the exponents and keep the borrow as the top bit.
    always_comb begin
        diff   = {1'b0, ea} - {1'b0, eb};
        borrow = diff[EXP_W];
    end

    // Gap magnitude and larger exponent, both chosen by the borrow.
    always_comb begin
        gap     = borrow ? (eb - ea) : diff[EXP_W-1:0];
        e_large = borrow ? eb : ea;
    end

    // Biased exponent sum for the multiply path.
    always_comb begin
        e_sum = {2'b00, ea} + {2'b00, eb} - BIAS_V;
    end
endmodule

// File: rtl/fpa_rshift.sv
// Logarithmic right shifter that settles in one cycle. Stage k moves the
// data by 2**k when bit k of the amount is set. A stage whose step is not
// smaller than the data width clears the data, so any amount of W or more
// gives zero.
module fpa_rshift #(
    parameter int W    = 24,
    parameter int SH_W = 8
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt,
    output logic [W-1:0]    dout
);
    logic [W-1:0] stg [0:SH_W];

    assign stg[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam longint STEP = longint'(1) << k;
        if (STEP < W) begin : g_move
            // Shift by this stage's step when its amount bit is set.
            assign stg[k+1] = amt[k] ? (stg[k] >> STEP) : stg[k];
        end else begin : g_flush
            // The step is at least the full width, so the data clears.
            assign stg[k+1] = amt[k] ? '0 : stg[k];
        end
    end

    assign dout = stg[SH_W];
endmodule

// File: rtl/fp_align_stage.sv
// Operand alignment stage. Unpacks two operands and compares their exponents.
// The significand of the operand with the smaller exponent is shifted right by
// the gap, and the result is registered. The exponent path gives either the
// larger exponent or the biased sum. Assumes no NaN or infinity handling.
// Latency is one cycle. Reset is synchronous and active low.
module fp_align_stage #(
    parameter int EXP_W  = fpa_pkg::DEF_EXP_W,
    parameter int FRAC_W = fpa_pkg::DEF_FRAC_W,
    parameter int BIAS   = fpa_pkg::DEF_BIAS,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int MANT_W = FRAC_W + 1,
    localparam int SUM_W  = EXP_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              exp_sum_sel,
    output logic              sign_a_q,
    output logic              sign_b_q,
    output logic [MANT_W-1:0] mant_a_q,
    output logic [MANT_W-1:0] mant_b_q,
    output logic [SUM_W-1:0]  exp_q,
    output logic              shift_sel_q
);
    import fpa_pkg::*;

    logic              sa, sb;
    logic [EXP_W-1:0]  ea, eb, gap, e_large;
    logic [MANT_W-1:0] ma, mb, shift_in, shift_out;
    logic [MANT_W-1:0] ma_next, mb_next;
    logic [SUM_W-1:0]  e_sum, exp_next;
    logic              borrow;
    exp_path_e         path;

    fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_a (
        .word(op_a), .sign(sa), .expo(ea), .mant(ma)
    );

    fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_b (
        .word(op_b), .sign(sb), .expo(eb), .mant(mb)
    );

    fpa_exp_cmp #(.EXP_W(EXP_W), .BIAS(BIAS)) u_exp_cmp (
        .ea(ea), .eb(eb), .borrow(borrow), .gap(gap),
        .e_large(e_large), .e_sum(e_sum)
    );

    // The borrow picks which significand enters the shifter.
    assign shift_in = borrow ? ma : mb;

    fpa_rshift #(.W(MANT_W), .SH_W(EXP_W)) u_shift (
        .din(shift_in), .amt(gap), .dout(shift_out)
    );

    // Steer the shifted and unshifted significands to their lanes, and
    // choose the exponent path.
    always_comb begin
        path     = exp_path_e'(exp_sum_sel);
        ma_next  = borrow ? shift_out : ma;
        mb_next  = borrow ? mb : shift_out;
        exp_next = (path == EXP_SUM) ? e_sum : {2'b00, e_large};
    end

    // Pipeline register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_a_q    <= 1'b0;
            sign_b_q    <= 1'b0;
            mant_a_q    <= '0;
            mant_b_q    <= '0;
            exp_q       <= '0;
            shift_sel_q <= 1'b0;
        end else begin
            sign_a_q    <= sa;
            sign_b_q    <= sb;
            mant_a_q    <= ma_next;
            mant_b_q    <= mb_next;
            exp_q       <= exp_next;
            shift_sel_q <= borrow;
        end
    end
endmodule

// File: rtl/fp_align_stage_chk.sv
// Property checker for the alignment stage, bound to the top module. It
// relates the registered outputs to the operands of the previous cycle.
module fp_align_stage_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int BIAS   = 127,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int MANT_W = FRAC_W + 1,
    localparam int SUM_W  = EXP_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              exp_sum_sel,
    input logic              sign_a_q,
    input logic              sign_b_q,
    input logic [MANT_W-1:0] mant_a_q,
    input logic [MANT_W-1:0] mant_b_q,
    input logic [SUM_W-1:0]  exp_q,
    input logic              shift_sel_q
);
    logic [EXP_W-1:0]  xa, xb;
    logic [MANT_W-1:0] full_a, full_b;
    logic [SUM_W-1:0]  want_sum;

    assign xa       = op_a[WORD_W-2 -: EXP_W];
    assign xb       = op_b[WORD_W-2 -: EXP_W];
    assign full_a   = {(xa != '0), op_a[FRAC_W-1:0]};
    assign full_b   = {(xb != '0), op_b[FRAC_W-1:0]};
    assign want_sum = SUM_W'(xa) + SUM_W'(xb) - SUM_W'(BIAS);

    // R2
    borrow_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (shift_sel_q == $past(xa < xb)));

    // R3
    a_unshifted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xa >= xb) |=> (mant_a_q == $past(full_a)));

    // R4
    b_unshifted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xa < xb) |=> (mant_b_q == $past(full_b)));

    // R6
    flush_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((EXP_W+1)'(xa) >= (EXP_W+1)'(xb) + (EXP_W+1)'(MANT_W)) |=> (mant_b_q == '0));

    // R7
    exp_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_sum_sel |=> (exp_q == $past(want_sum)));

    // R8
    exp_large_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exp_sum_sel && xa >= xb) |=> (exp_q == SUM_W'($past(xa))));

    // R9
    sign_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sign_a_q == $past(op_a[WORD_W-1]) && sign_b_q == $past(op_b[WORD_W-1])));
endmodule

bind fp_align_stage fp_align_stage_chk #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .exp_sum_sel(exp_sum_sel), .sign_a_q(sign_a_q), .sign_b_q(sign_b_q),
    .mant_a_q(mant_a_q), .mant_b_q(mant_b_q), .exp_q(exp_q),
    .shift_sel_q(shift_sel_q)
);

// File: tb/fp_align_stage_test.sv
// Bench: a vector table walked by one loop, then directed reset and
// latency tests. Expected values come from a reference model written from
// the requirements.
module fp_align_stage_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        exp_sum_sel = 1'b0;
    logic        sign_a_q, sign_b_q, shift_sel_q;
    logic [23:0] mant_a_q, mant_b_q;
    logic [9:0]  exp_q;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    fp_align_stage uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .exp_sum_sel(exp_sum_sel), .sign_a_q(sign_a_q), .sign_b_q(sign_b_q),
        .mant_a_q(mant_a_q), .mant_b_q(mant_b_q), .exp_q(exp_q),
        .shift_sel_q(shift_sel_q)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Vector: {op_a, op_b, multiply mode}
    localparam int NV = 14;
    localparam logic [64:0] VEC [0:NV-1] = '{
        {32'h3f800000, 32'h40000000, 1'b0},  // A smaller by 1
        {32'h40400000, 32'h3f800000, 1'b0},  // B smaller by 1
        {32'h3fc00000, 32'hbf800000, 1'b0},  // equal exponents, signs differ
        {32'h4f000000, 32'h3f800000, 1'b0},  // gap 31
        {32'h4b000000, 32'h3fffffff, 1'b0},  // gap 23
        {32'h4b800000, 32'h3fffffff, 1'b0},  // gap 24
        {32'h3fffffff, 32'h4b000000, 1'b0},  // gap 23, A smaller
        {32'h3fffffff, 32'h4b800000, 1'b0},  // gap 24, A smaller
        {32'h00400000, 32'h00000001, 1'b0},  // both zero exponent
        {32'h7f000000, 32'h00400000, 1'b0},  // gap 254
        {32'h40000000, 32'h40400000, 1'b1},  // multiply, equal exps
        {32'h00800000, 32'h80800000, 1'b1},  // multiply, sum below zero
        {32'h7f000000, 32'h7f000000, 1'b1},  // multiply, sum above 255
        {32'hc1200000, 32'h3e000000, 1'b1}   // multiply, unequal exps
    };

    logic [23:0] x_ma, x_mb;
    logic [9:0]  x_exp;
    logic        x_sel, x_sa, x_sb;

    // Reference model written from R1..R9.
    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic m);
        int ea, eb, d;
        logic [23:0] fa, fb;
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        fa = {(ea != 0), a[22:0]};
        fb = {(eb != 0), b[22:0]};
        x_sa  = a[31];
        x_sb  = b[31];
        x_sel = (ea < eb);
        if (ea < eb) begin
            d = eb - ea;
            x_ma = (d >= 24) ? 24'd0 : (fa >> d);
            x_mb = fb;
        end else begin
            d = ea - eb;
            x_ma = fa;
            x_mb = (d >= 24) ? 24'd0 : (fb >> d);
        end
        if (m) x_exp = 10'(ea + eb - 127);
        else   x_exp = 10'((ea > eb) ? ea : eb);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input int idx);
        string mtag, etag;
        if (x_sel)                               mtag = "R4";
        else if (VEC[idx][63:56] == VEC[idx][31:24] &&
                 VEC[idx][55] == VEC[idx][23])   mtag = "R5";
        else                                     mtag = "R3";
        etag = exp_sum_sel ? "R7" : "R8";
        check($sformatf("%s mant_a v%0d", mtag, idx), 32'(mant_a_q), 32'(x_ma));
        check($sformatf("%s mant_b v%0d", mtag, idx), 32'(mant_b_q), 32'(x_mb));
        check($sformatf("R2 shift_sel v%0d", idx), 32'(shift_sel_q), 32'(x_sel));
        check($sformatf("%s exp v%0d", etag, idx), 32'(exp_q), 32'(x_exp));
        check($sformatf("R9 signs v%0d", idx), 32'({sign_a_q, sign_b_q}), 32'({x_sa, x_sb}));
    endtask

    // Watchdog: a hung run counts as a failure and still ends with a summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: reset clears every output, even with live inputs.
        op_a = 32'hc0400000; op_b = 32'h41000000; exp_sum_sel = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 reset mant_a", 32'(mant_a_q), 32'd0);
        check("R10 reset mant_b", 32'(mant_b_q), 32'd0);
        check("R10 reset exp/sel/signs", 32'({exp_q, shift_sel_q, sign_a_q, sign_b_q}), 32'd0);
        rst_n = 1'b1;

        // Vector table: drive on a falling edge, check on the next one.
        for (int i = 0; i < NV; i++) begin
            op_a = VEC[i][64:33];
            op_b = VEC[i][32:1];
            exp_sum_sel = VEC[i][0];
            model(op_a, op_b, exp_sum_sel);
            @(negedge clk);
            check_all(i);
        end

        // R1: a zero exponent drops the hidden bit, a nonzero one sets it.
        op_a = 32'h00000005; op_b = 32'h00800005; exp_sum_sel = 1'b0;
        @(negedge clk);
        check("R1 hidden bit B", 32'(mant_b_q), 32'h800005);
        check("R1 no hidden bit A", 32'(mant_a_q), 32'h000002);

        // R6: a gap of 23 keeps only the former top bit.
        op_a = 32'h4b7fffff; op_b = 32'h3f800000;
        @(negedge clk);
        check("R6 gap 23 keeps top bit", 32'(mant_b_q), 32'h000001);

        // R10: outputs hold until the next rising edge, then follow.
        op_a = 32'h3f800000; op_b = 32'h40000000;
        #2;
        check("R10 output holds before edge", 32'(mant_b_q), 32'h000001);
        @(negedge clk);
        check("R10 output after edge", 32'(mant_a_q), 32'h400000);

        // R10: a reset in mid-run clears the register at the next edge.
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid-run reset", 32'({mant_a_q, shift_sel_q}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule